// File: doc/BRIEF.md
# Configurable I2S/TDM Serial Audio Port

This block is a slave-side serial audio port. An external master drives the bit clock and the frame clock. The block samples both, along with the incoming serial data, in its own system clock domain and finds the active bit-clock edges there. It receives playback samples and sends record samples on the same bit clock and frame clock. The frame holds two, four or eight channel slots. The slot width is the programmed bit-clock count per frame divided by the number of channels.

Configuration inputs set the following: the channel count, the bit clocks per frame, the MSB delay after each slot boundary, the word length, the polarity of both clocks, and which channel pair carries each direction. Received samples leave as a left/right pair on parallel buses, with a one-cycle valid strobe. Samples to transmit come in on two parallel buses. The configuration is meant to stay static while reset is released.

Top module: `tdm_serial_port`

## Requirements
- R1: After reset, `sdataOut`, `rxValid`, `rxLeft` and `rxRight` are all zero.
- R2: A frame starts at the rising effective bit-clock edge where the effective frame clock is first seen low after being high. Until the first frame start, `sdataOut` stays 0 and `rxValid` never pulses.
- R3: `chanMode` 0 gives 2 channels, 1 gives 4 and 2 gives 8. Each slot lasts `frameBclks` divided by the channel count.
- R4: `msbDelay` 0, 1 and 2 place a slot's MSB 0, 1 and 8 bit clocks after the start of the slot.
- R5: Words are MSB first and `wordLen` bits long (16 to 24). A received word is placed at the top of the 24-bit bus with zeros below it. For transmit, the top `wordLen` bits of the sample are sent.
- R6: Playback pair p receives its left word in slot 2p and its right word in slot 2p+1. In 2-channel mode the pair code is ignored. In 4-channel mode only bit 0 of the code is used. Bits outside the selected words are ignored.
- R7: The record pair code selects the transmit slots in the same way. `sdataOut` is 0 in every bit that is outside the selected words.
- R8: `rxValid` is a single-cycle pulse, once per frame, after the last bit of the right word. `rxLeft` and `rxRight` are valid while it is high.
- R9: `txLeft` and `txRight` are captured at the rising edge of the last bit of each frame and are sent in the following frame. Reset clears the captured values.
- R10: With `bclkInvert` at 0, input is sampled on the bit-clock rising edge and output changes after the falling edge. With `bclkInvert` at 1 the two edges swap.
- R11: `lrclkInvert` at 1 inverts the frame clock level before frame detection and left/right decoding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, fast enough to oversample the bit clock |
| rstN | input | 1 | Active-low synchronous reset |
| bclkIn | input | 1 | Bit clock from the master |
| lrclkIn | input | 1 | Frame clock from the master |
| sdataIn | input | 1 | Serial playback data |
| sdataOut | output | 1 | Serial record data |
| chanMode | input | 2 | Channels per frame: 0 two, 1 four, 2 eight |
| frameBclks | input | 9 | Bit clocks per frame |
| msbDelay | input | 2 | MSB delay code: 0, 1 or 8 bit clocks |
| wordLen | input | 5 | Word length in bits, 16 to 24 |
| bclkInvert | input | 1 | Swap the sampling and driving bit-clock edges |
| lrclkInvert | input | 1 | Invert the frame clock level |
| playPair | input | 2 | Channel pair received for playback |
| recPair | input | 2 | Channel pair transmitted for record |
| txLeft | input | 24 | Left record sample, MSB aligned |
| txRight | input | 24 | Right record sample, MSB aligned |
| rxLeft | output | 24 | Left playback sample, MSB aligned |
| rxRight | output | 24 | Right playback sample, MSB aligned |
| rxValid | output | 1 | One-cycle strobe marking a new received pair |

## Verification
Some properties are checked on every cycle. The frame position and the slot index must stay inside the programmed frame. Lock must be sticky once a frame start has been seen. `rxValid` must never last more than one cycle. The serial output may change only in the cycle after a driving bit-clock edge.

Other behaviour can only be shown by the bench scenarios. These cover where each bit lands for every MSB delay and word length, the ignoring of bits outside the selected pair, the one-frame lag of the transmit samples, and the effect of the polarity inversions. The bench compares the serial output bit by bit against its model of the frame.

// File: rtl/tdm_port_pkg.sv
package tdm_port_pkg;

  typedef enum logic [1:0] {
    CH_TWO   = 2'd0,
    CH_FOUR  = 2'd1,
    CH_EIGHT = 2'd2
  } chan_mode_e;

  // strobes from control to datapath, one system cycle wide
  typedef struct packed {
    logic capL;     // shift rxBit into the left receive word
    logic capR;     // shift rxBit into the right receive word
    logic rxBit;    // synchronised serial input
    logic rxDone;   // right word complete, publish the pair
    logic loadTx;   // capture the parallel transmit samples
    logic txFall;   // driving edge: update the serial output
    logic txEn;     // the driven bit lies in a selected word
    logic txRight;  // the driven bit belongs to the right word
  } strobe_t;

endpackage

// File: rtl/tdm_port_ctrl.sv
module tdm_port_ctrl
  import tdm_port_pkg::*;
#(
  parameter int SAMPLE_W    = 24,
  parameter int FB_W        = 9,
  parameter int WL_W        = 5,
  parameter int SYNC_STAGES = 2,
  localparam int IDX_W      = $clog2(SAMPLE_W)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bclkIn,
  input  logic             lrclkIn,
  input  logic             sdataIn,
  input  logic [1:0]       chanMode,
  input  logic [FB_W-1:0]  frameBclks,
  input  logic [1:0]       msbDelay,
  input  logic [WL_W-1:0]  wordLen,
  input  logic             bclkInvert,
  input  logic             lrclkInvert,
  input  logic [1:0]       playPair,
  input  logic [1:0]       recPair,
  output strobe_t          st,
  output logic [IDX_W-1:0] txOffset
);

  logic [SYNC_STAGES-1:0] bSync, lSync, dSync;
  logic bEff, bPrevEff, lrEff, lrPrev;
  logic riseEv, fallEv, frameStart;
  logic locked, nowLocked, rxDoneQ;
  logic [FB_W-1:0] pos, ins, advPos, advIns, nPos, nIns;
  logic [2:0] slot, advSlot, nSlot;
  logic [1:0] chShift;
  logic [FB_W-1:0] slotLen, lastPos, lastIn, dly, wEnd, offFull;
  logic [2:0] rxSlotL, rxSlotR, txSlotL, txSlotR;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bSync <= '0;
      lSync <= '0;
      dSync <= '0;
    end else begin
      bSync <= {bSync[SYNC_STAGES-2:0], bclkIn};
      lSync <= {lSync[SYNC_STAGES-2:0], lrclkIn};
      dSync <= {dSync[SYNC_STAGES-2:0], sdataIn};
    end
  end

  assign bEff       = bSync[SYNC_STAGES-1] ^ bclkInvert;
  assign lrEff      = lSync[SYNC_STAGES-1] ^ lrclkInvert;
  assign riseEv     = bEff & ~bPrevEff;
  assign fallEv     = ~bEff & bPrevEff;
  assign frameStart = riseEv & lrPrev & ~lrEff;
  assign nowLocked  = locked | frameStart;

  function automatic logic [1:0] maskPair(input logic [1:0] p, input logic [1:0] sh);
    case (sh)
      2'd1:    maskPair = 2'd0;
      2'd2:    maskPair = {1'b0, p[0]};
      default: maskPair = p;
    endcase
  endfunction

  always_comb begin
    case (chan_mode_e'(chanMode))
      CH_TWO:  chShift = 2'd1;
      CH_FOUR: chShift = 2'd2;
      default: chShift = 2'd3;
    endcase
    case (msbDelay)
      2'd0:    dly = FB_W'(0);
      2'd1:    dly = FB_W'(1);
      default: dly = FB_W'(8);
    endcase
  end

  assign slotLen = frameBclks >> chShift;
  assign lastPos = frameBclks - FB_W'(1);
  assign lastIn  = slotLen - FB_W'(1);
  assign wEnd    = dly + FB_W'(wordLen);
  assign rxSlotL = {maskPair(playPair, chShift), 1'b0};
  assign rxSlotR = {maskPair(playPair, chShift), 1'b1};
  assign txSlotL = {maskPair(recPair, chShift), 1'b0};
  assign txSlotR = {maskPair(recPair, chShift), 1'b1};

  // position of the bit after the current one, assuming no new frame marker
  always_comb begin
    if (pos == lastPos) begin
      advPos = '0; advIns = '0; advSlot = '0;
    end else if (ins == lastIn) begin
      advPos = pos + FB_W'(1); advIns = '0; advSlot = slot + 3'd1;
    end else begin
      advPos = pos + FB_W'(1); advIns = ins + FB_W'(1); advSlot = slot;
    end
    if (frameStart) begin
      nPos = '0; nIns = '0; nSlot = '0;
    end else begin
      nPos = advPos; nIns = advIns; nSlot = advSlot;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bPrevEff <= 1'b0;
      lrPrev   <= 1'b0;
      locked   <= 1'b0;
      pos      <= '0;
      ins      <= '0;
      slot     <= '0;
      rxDoneQ  <= 1'b0;
    end else begin
      bPrevEff <= bEff;
      rxDoneQ  <= st.capR && (nIns == wEnd - FB_W'(1));
      if (riseEv) begin
        lrPrev <= lrEff;
        if (frameStart) locked <= 1'b1;
        if (nowLocked) begin
          pos  <= nPos;
          ins  <= nIns;
          slot <= nSlot;
        end
      end
    end
  end

  assign offFull  = advIns - dly;
  assign txOffset = offFull[IDX_W-1:0];

  always_comb begin
    st.rxBit   = dSync[SYNC_STAGES-1];
    st.capL    = riseEv & nowLocked & (nSlot == rxSlotL) & (nIns >= dly) & (nIns < wEnd);
    st.capR    = riseEv & nowLocked & (nSlot == rxSlotR) & (nIns >= dly) & (nIns < wEnd);
    st.rxDone  = rxDoneQ;
    st.loadTx  = riseEv & nowLocked & (nPos == lastPos);
    st.txFall  = fallEv;
    st.txRight = (advSlot == txSlotR);
    st.txEn    = locked & (advIns >= dly) & (advIns < wEnd) &
                 ((advSlot == txSlotL) | (advSlot == txSlotR));
  end

  assert_pos_range_R3: assert property (@(posedge clk) disable iff (!rstN)
    locked |-> (pos <= lastPos));
  assert_slot_range_R3: assert property (@(posedge clk) disable iff (!rstN)
    locked |-> ({1'b0, slot} < (4'd1 << chShift)));
  assert_lock_sticky_R2: assert property (@(posedge clk) disable iff (!rstN)
    locked |=> locked);

endmodule

// File: rtl/tdm_port_datapath.sv
module tdm_port_datapath
  import tdm_port_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int WL_W     = 5,
  localparam int IDX_W   = $clog2(SAMPLE_W)
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             st,
  input  logic [IDX_W-1:0]    txOffset,
  input  logic [WL_W-1:0]     wordLen,
  input  logic [SAMPLE_W-1:0] txLeft,
  input  logic [SAMPLE_W-1:0] txRight,
  output logic                sdataOut,
  output logic [SAMPLE_W-1:0] rxLeft,
  output logic [SAMPLE_W-1:0] rxRight,
  output logic                rxValid
);

  logic [SAMPLE_W-1:0] shL, shR, holdL, holdR, txWord;
  logic [WL_W-1:0]     alignShift;
  logic [IDX_W-1:0]    bitIdx;

  assign alignShift = WL_W'(SAMPLE_W) - wordLen;
  assign bitIdx     = IDX_W'(SAMPLE_W - 1) - txOffset;
  assign txWord     = st.txRight ? holdR : holdL;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shL      <= '0;
      shR      <= '0;
      holdL    <= '0;
      holdR    <= '0;
      rxLeft   <= '0;
      rxRight  <= '0;
      rxValid  <= 1'b0;
      sdataOut <= 1'b0;
    end else begin
      if (st.capL) shL <= {shL[SAMPLE_W-2:0], st.rxBit};
      if (st.capR) shR <= {shR[SAMPLE_W-2:0], st.rxBit};
      rxValid <= st.rxDone;
      if (st.rxDone) begin
        rxLeft  <= shL << alignShift;
        rxRight <= shR << alignShift;
      end
      if (st.loadTx) begin
        holdL <= txLeft;
        holdR <= txRight;
      end
      if (st.txFall) sdataOut <= st.txEn ? txWord[bitIdx] : 1'b0;
    end
  end

  assert_valid_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);
  assert_tx_on_fall_R10: assert property (@(posedge clk) disable iff (!rstN)
    (sdataOut != $past(sdataOut)) |-> $past(st.txFall));

endmodule

// File: rtl/tdm_serial_port.sv
module tdm_serial_port
  import tdm_port_pkg::*;
#(
  parameter int SAMPLE_W    = 24,
  parameter int MAX_FRAME   = 256,
  parameter int SYNC_STAGES = 2,
  localparam int FB_W       = $clog2(MAX_FRAME + 1),
  localparam int WL_W       = $clog2(SAMPLE_W + 1),
  localparam int IDX_W      = $clog2(SAMPLE_W)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                bclkIn,
  input  logic                lrclkIn,
  input  logic                sdataIn,
  output logic                sdataOut,
  input  logic [1:0]          chanMode,
  input  logic [FB_W-1:0]     frameBclks,
  input  logic [1:0]          msbDelay,
  input  logic [WL_W-1:0]     wordLen,
  input  logic                bclkInvert,
  input  logic                lrclkInvert,
  input  logic [1:0]          playPair,
  input  logic [1:0]          recPair,
  input  logic [SAMPLE_W-1:0] txLeft,
  input  logic [SAMPLE_W-1:0] txRight,
  output logic [SAMPLE_W-1:0] rxLeft,
  output logic [SAMPLE_W-1:0] rxRight,
  output logic                rxValid
);

  strobe_t          st;
  logic [IDX_W-1:0] txOffset;

  tdm_port_ctrl #(
    .SAMPLE_W(SAMPLE_W), .FB_W(FB_W), .WL_W(WL_W), .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .bclkIn(bclkIn), .lrclkIn(lrclkIn), .sdataIn(sdataIn),
    .chanMode(chanMode), .frameBclks(frameBclks), .msbDelay(msbDelay),
    .wordLen(wordLen), .bclkInvert(bclkInvert), .lrclkInvert(lrclkInvert),
    .playPair(playPair), .recPair(recPair), .st(st), .txOffset(txOffset)
  );

  tdm_port_datapath #(
    .SAMPLE_W(SAMPLE_W), .WL_W(WL_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .txOffset(txOffset), .wordLen(wordLen),
    .txLeft(txLeft), .txRight(txRight), .sdataOut(sdataOut),
    .rxLeft(rxLeft), .rxRight(rxRight), .rxValid(rxValid)
  );

endmodule

// File: tb/tdm_serial_port_tb.sv
module tdm_serial_port_tb;
  localparam int W = 24;
  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bclkIn = 1'b1, lrclkIn = 1'b1, sdataIn = 1'b0;
  logic sdataOut, rxValid;
  logic [1:0] chanMode = 2'd0, msbDelay = 2'd1, playPair = 2'd0, recPair = 2'd0;
  logic [8:0] frameBclks = 9'd64;
  logic [4:0] wordLen = 5'd24;
  logic bclkInvert = 1'b0, lrclkInvert = 1'b0;
  logic [W-1:0] txLeft = '0, txRight = '0, rxLeft, rxRight;

  int checks = 0, failures = 0, validCount = 0;
  bit done = 0;
  logic [W-1:0] expL[$], expR[$];
  string rxTag = "R5";

  always #2 clk = ~clk;

  tdm_serial_port u_dut (
    .clk(clk), .rstN(rstN), .bclkIn(bclkIn), .lrclkIn(lrclkIn), .sdataIn(sdataIn),
    .sdataOut(sdataOut), .chanMode(chanMode), .frameBclks(frameBclks),
    .msbDelay(msbDelay), .wordLen(wordLen), .bclkInvert(bclkInvert),
    .lrclkInvert(lrclkInvert), .playPair(playPair), .recPair(recPair),
    .txLeft(txLeft), .txRight(txRight), .rxLeft(rxLeft), .rxRight(rxRight),
    .rxValid(rxValid)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // receive monitor, evaluated on every clock away from the active edge
  always @(negedge clk) begin
    if (rstN && rxValid) begin
      validCount++;
      if (expL.size() == 0) begin
        check(0, "R8", "unexpected rxValid", 1, 0);
      end else begin
        logic [W-1:0] eL, eR;
        eL = expL.pop_front();
        eR = expR.pop_front();
        check(rxLeft == eL, rxTag, "rxLeft", rxLeft, eL);
        check(rxRight == eR, rxTag, "rxRight", rxRight, eR);
      end
    end
  end

  task automatic bitTick(input bit lrE, input bit sd, input bit binv, input bit linv,
                         input bit expTx, input string txTag);
    bclkIn  = binv;            // effective falling edge
    lrclkIn = lrE ^ linv;
    sdataIn = sd;
    repeat (HALF) @(negedge clk);
    check(sdataOut == expTx, txTag, "sdataOut bit", sdataOut, expTx);
    bclkIn = ~binv;            // effective rising edge
    repeat (HALF) @(negedge clk);
  endtask

  task automatic scenario(input int cm, input int fb, input int dc, input int wl,
                          input int dp, input int ap, input bit binv, input bit linv,
                          input int nFrames, input string txTag, input string rTag);
    int ch, sw, d, rp, tp;
    logic [W-1:0] holdL, holdR, mask;
    rstN = 1'b0;
    chanMode = 2'(cm); frameBclks = 9'(fb); msbDelay = 2'(dc); wordLen = 5'(wl);
    playPair = 2'(dp); recPair = 2'(ap); bclkInvert = binv; lrclkInvert = linv;
    bclkIn = ~binv; lrclkIn = ~linv; sdataIn = 1'b0; txLeft = '0; txRight = '0;
    rxTag = rTag;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    validCount = 0;
    ch = 2 << cm; sw = fb / ch;
    d  = (dc == 0) ? 0 : (dc == 1) ? 1 : 8;
    rp = (cm == 0) ? 0 : (cm == 1) ? (dp & 1) : dp;
    tp = (cm == 0) ? 0 : (cm == 1) ? (ap & 1) : ap;
    mask = ~((W'(1) << (W - wl)) - W'(1));
    holdL = '0; holdR = '0;
    // R2: frame clock held high, no frame start yet
    for (int i = 0; i < 4; i++) bitTick(1'b1, 1'($urandom), binv, linv, 1'b0, "R2");
    for (int f = 0; f < nFrames; f++) begin
      logic [W-1:0] wL, wR, nL, nR;
      wL = W'($urandom); wR = W'($urandom);
      nL = W'($urandom); nR = W'($urandom);
      expL.push_back(wL & mask);
      expR.push_back(wR & mask);
      for (int p = 0; p < fb; p++) begin
        int slot, ins;
        bit sd, ex, inWin;
        slot = p / sw; ins = p % sw;
        inWin = (ins >= d) && (ins < d + wl);
        if (inWin && slot == 2*rp)        sd = wL[W-1-(ins-d)];
        else if (inWin && slot == 2*rp+1) sd = wR[W-1-(ins-d)];
        else                              sd = 1'($urandom);
        if (inWin && slot == 2*tp)        ex = holdL[W-1-(ins-d)];
        else if (inWin && slot == 2*tp+1) ex = holdR[W-1-(ins-d)];
        else                              ex = 1'b0;
        if (p == 0) begin txLeft = nL; txRight = nR; end
        bitTick((p < fb/2) ? 1'b0 : 1'b1, sd, binv, linv, ex, txTag);
        if (p == fb - 1) begin holdL = txLeft; holdR = txRight; end
      end
    end
    repeat (4) @(negedge clk);
    check(validCount == nFrames, "R8", "rxValid pulses per scenario", validCount, nFrames);
    check(expL.size() == 0, "R8", "pending received pairs", expL.size(), 0);
    expL.delete(); expR.delete();
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check(sdataOut == 1'b0, "R1", "sdataOut in reset", sdataOut, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(rxValid == 1'b0, "R1", "rxValid after reset", rxValid, 0);
    check(rxLeft == '0 && rxRight == '0, "R1", "rx buses after reset", rxLeft, 0);
    // standard I2S, 2 channels, 64 bit clocks
    scenario(0, 64, 1, 24, 0, 0, 1'b0, 1'b0, 4, "R7", "R5");
    // left-justified, 16-bit words, pair codes ignored, bit clock inverted
    scenario(0, 48, 0, 16, 3, 2, 1'b1, 1'b0, 4, "R10", "R6");
    // 4 channels, MSB delay 8, frame clock inverted
    scenario(1, 128, 2, 24, 1, 0, 1'b0, 1'b1, 3, "R4", "R11");
    // 8 channels, 20-bit words
    scenario(2, 256, 1, 20, 2, 3, 1'b0, 1'b0, 3, "R3", "R5");
    // 8 channels, both clocks inverted, tx lag across frames
    scenario(2, 256, 0, 24, 3, 1, 1'b1, 1'b1, 3, "R9", "R6");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R8 watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule